// File: doc/BRIEF.md
# Edge-Detect Interrupt Capture Unit

This block watches 24 already-synchronized input lines, grouped as three 8-bit ports. It catches signal edges on them and turns them into a level interrupt request. Each line has its own polarity bit and its own enable bit. The polarity bit chooses whether a rising or a falling transition counts as an event, and the enable bit decides whether the line may record events at all. A recorded event sets a sticky identification bit. That bit stays set until software clears it by writing a zero to it.

The unit sits behind a byte-wide paged register port. Three banks hold the polarity, enable and identification bytes. A fourth, read-only status bank returns a per-port pending summary in its low three bits. Software services the interrupt by reading the identification bytes and writing zeros back to them. A write to an identification byte clears only the bits written as 0. An edge that arrives in the same cycle as a clear takes precedence, so no event is lost. Edges are found by comparing the current pin level with the level one clock earlier. That stored level follows the pins at all times, so reprogramming polarity or enable never creates an event by itself.

The interface is plain control and status; there is no streaming data path, so no valid/ready handshake is involved. Writes take effect on the clock edge. Reads are combinational from the bank and byte select.

Top module: `hdio_edge_capture`

## Requirements
- R1: After reset, every polarity, enable and identification bit reads 0, the pending summary is 000 and irq_o is low.
- R2: With polarity bit 1 and enable bit 1, a 0-to-1 change on a line sets its identification bit, which is readable one clock edge after the change is sampled.
- R3: With polarity bit 0 and enable bit 1, a 1-to-0 change on a line sets its identification bit; a change in the opposite direction does not.
- R4: A line whose enable bit is 0 never sets its identification bit, whatever its pin does.
- R5: An identification bit stays set until it is cleared by a write, and irq_o is high exactly while any identification bit is set.
- R6: A write to an identification byte clears exactly the bits written as 0. Bits written as 1 keep their value and are never set by the write.
- R7: If an edge on an enabled line and a clearing write to that line's bit occur in the same cycle, the bit ends up set.
- R8: The status bank (bank code 0) reads with bit p set when port p (lines 8p to 8p+7) has any identification bit set. Bits 7:3 read 0, the pending_o pins carry the same three bits, and a write to the status bank changes nothing.
- R9: Changing polarity or enable bits while the pins are stable never sets an identification bit.
- R10: Polarity (bank code 1) and enable (bank code 2) bytes read back as written. Identification bytes use bank code 3. The byte index selects lines 8i to 8i+7, and index 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 24 | Synchronized pin levels, line n on bit n |
| wr_en | input | 1 | Register write strobe, one byte per cycle |
| wr_bank | input | 2 | Write bank: 0 status, 1 polarity, 2 enable, 3 identification |
| wr_idx | input | 2 | Write byte index (port number) |
| wr_data | input | 8 | Write data |
| rd_bank | input | 2 | Read bank select, same codes as wr_bank |
| rd_idx | input | 2 | Read byte index |
| rd_data | output | 8 | Combinational read data |
| pending_o | output | 3 | Per-port pending summary |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The assertions assume pin_i is already synchronous to clk and holds one stable value per cycle, so a newly set identification bit can always be traced to an enabled, correctly directed transition between the two previous samples. The bench changes pins, register writes and read selects only at falling clock edges. It holds the pins stable while it reprograms polarity or enable, and it only issues clears through the identification bank. Under these conditions, the only way an identification bit can drop is through a write.

// File: rtl/hdio_edge_pkg.sv
package hdio_edge_pkg;
  typedef enum logic [1:0] {
    BANK_STAT = 2'd0,
    BANK_POL  = 2'd1,
    BANK_EN   = 2'd2,
    BANK_ID   = 2'd3
  } bank_e;
endpackage

// File: rtl/hdio_edge_port.sv
module hdio_edge_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic         wr_pol,
  input  logic         wr_ena,
  input  logic         wr_id,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] id_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise, fall, hit;

  // previous level follows the pins unconditionally
  always_ff @(posedge clk) prev_q <= pin_i;

  assign rise = pin_i & ~prev_q;
  assign fall = ~pin_i & prev_q;
  assign hit  = en_o & ((pol_o & rise) | (~pol_o & fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_o <= '0;
      en_o  <= '0;
      id_o  <= '0;
    end else begin
      if (wr_pol) pol_o <= wdata;
      if (wr_ena) en_o  <= wdata;
      // clear-by-zero, edge of the same cycle wins
      id_o <= (wr_id ? (id_o & wdata) : id_o) | hit;
    end
  end
endmodule

// File: rtl/hdio_edge_summary.sv
module hdio_edge_summary #(
  parameter int NPORT  = 3,
  parameter int PORT_W = 8
) (
  input  logic [NPORT*PORT_W-1:0] id_all,
  output logic [NPORT-1:0]        pending,
  output logic                    irq
);
  for (genvar p = 0; p < NPORT; p++) begin : g_sum
    assign pending[p] = |id_all[p*PORT_W +: PORT_W];
  end
  assign irq = |pending;
endmodule

// File: rtl/hdio_edge_capture.sv
module hdio_edge_capture
  import hdio_edge_pkg::*;
#(
  parameter int NPORT  = 3,
  parameter int PORT_W = 8,
  localparam int NLINE = NPORT * PORT_W,
  localparam int IDXW  = (NPORT > 1) ? $clog2(NPORT + 1) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE-1:0] pin_i,
  input  logic             wr_en,
  input  logic [1:0]       wr_bank,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [PORT_W-1:0] wr_data,
  input  logic [1:0]       rd_bank,
  input  logic [IDXW-1:0]  rd_idx,
  output logic [PORT_W-1:0] rd_data,
  output logic [NPORT-1:0] pending_o,
  output logic             irq_o
);
  logic [NLINE-1:0] pol_all, en_all, id_all;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic sel;
    assign sel = wr_en && (int'(wr_idx) == p);
    hdio_edge_port #(.W(PORT_W)) u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i[p*PORT_W +: PORT_W]),
      .wr_pol (sel && (bank_e'(wr_bank) == BANK_POL)),
      .wr_ena (sel && (bank_e'(wr_bank) == BANK_EN)),
      .wr_id  (sel && (bank_e'(wr_bank) == BANK_ID)),
      .wdata  (wr_data),
      .pol_o  (pol_all[p*PORT_W +: PORT_W]),
      .en_o   (en_all[p*PORT_W +: PORT_W]),
      .id_o   (id_all[p*PORT_W +: PORT_W])
    );
  end

  hdio_edge_summary #(.NPORT(NPORT), .PORT_W(PORT_W)) u_sum (
    .id_all  (id_all),
    .pending (pending_o),
    .irq     (irq_o)
  );

  always_comb begin
    rd_data = '0;
    if (bank_e'(rd_bank) == BANK_STAT) begin
      rd_data[NPORT-1:0] = pending_o;
    end else if (int'(rd_idx) < NPORT) begin
      case (bank_e'(rd_bank))
        BANK_POL: rd_data = pol_all[int'(rd_idx)*PORT_W +: PORT_W];
        BANK_EN:  rd_data = en_all[int'(rd_idx)*PORT_W +: PORT_W];
        default:  rd_data = id_all[int'(rd_idx)*PORT_W +: PORT_W];
      endcase
    end
  end
endmodule

// File: rtl/hdio_edge_chk.sv
module hdio_edge_chk
  import hdio_edge_pkg::*;
#(
  parameter int NPORT  = 3,
  parameter int PORT_W = 8,
  localparam int NLINE = NPORT * PORT_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NLINE-1:0] pin_i,
  input logic             wr_en,
  input logic [1:0]       wr_bank,
  input logic [NPORT-1:0] pending_o,
  input logic             irq_o,
  input logic [NLINE-1:0] pol_all,
  input logic [NLINE-1:0] en_all,
  input logic [NLINE-1:0] id_all
);
  logic [1:0]       cnt;
  logic [NLINE-1:0] pin_d1, pin_d2, en_d1, pol_d1, id_d1;
  logic             clr_d1;
  logic [NPORT-1:0] port_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; pin_d1 <= '0; pin_d2 <= '0; en_d1 <= '0;
      pol_d1 <= '0; id_d1 <= '0; clr_d1 <= 1'b0;
    end else begin
      if (cnt != 2'd2) cnt <= cnt + 2'd1;
      pin_d1 <= pin_i;
      pin_d2 <= pin_d1;
      en_d1  <= en_all;
      pol_d1 <= pol_all;
      id_d1  <= id_all;
      clr_d1 <= wr_en && (bank_e'(wr_bank) == BANK_ID);
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++)
      port_any[p] = (id_all[p*PORT_W +: PORT_W] != '0);
  end

  // R2 R3 R4 R9: a new id bit needs an enabled transition in the selected direction
  a_r2_edge_source: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd2) |-> ((id_all & ~id_d1 &
      ~(en_d1 & (pin_d1 ^ pin_d2) & ~(pol_d1 ^ pin_d1))) == '0));

  // R6: id bits only fall after a write to the identification bank
  a_r6_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 2'd0 && !clr_d1) |-> ((id_d1 & ~id_all) == '0));

  // R8: pending summary follows the latched ports
  a_r8_pending_map: assert property (@(posedge clk) disable iff (!rst_n)
    pending_o == port_any);

  // R5: request high exactly while something is latched
  a_r5_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (id_all != '0));

  // R5: with no clearing write the request cannot drop
  a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(wr_en && bank_e'(wr_bank) == BANK_ID)) |=> irq_o);
endmodule

bind hdio_edge_capture hdio_edge_chk #(.NPORT(NPORT), .PORT_W(PORT_W)) u_chk (.*);

// File: tb/tb_hdio_edge_capture.sv
`timescale 1ns/1ps
module tb_hdio_edge_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pin_i = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_bank = '0, wr_idx = '0, rd_bank = '0, rd_idx = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [2:0]  pending_o;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  hdio_edge_capture dut (.*);

  typedef struct packed {
    logic [23:0] pol, en, pin_a, pin_b, exp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{24'hFFFFFF, 24'hFFFFFF, 24'h000000, 24'hFFFFFF, 24'hFFFFFF}, // R2
    '{24'h000000, 24'hFFFFFF, 24'hFFFFFF, 24'h000000, 24'hFFFFFF}, // R3
    '{24'h00FF00, 24'hFFFFFF, 24'h0F0F0F, 24'hF0F0F0, 24'h0FF00F}, // R2 R3 mixed
    '{24'hFFFFFF, 24'h0000FF, 24'h000000, 24'hFFFFFF, 24'h0000FF}, // R4
    '{24'hFFFFFF, 24'hFFFFFF, 24'h123456, 24'h123456, 24'h000000}, // no change
    '{24'h000000, 24'hFF0000, 24'hA50000, 24'h5A0000, 24'hA50000}  // R3 R4
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] b, input logic [1:0] i, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = b; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr24(input logic [1:0] b, input logic [23:0] v);
    for (int i = 0; i < 3; i++) wr(b, 2'(i), v[i*8 +: 8]);
  endtask

  task automatic rd(input logic [1:0] b, input logic [1:0] i, output logic [7:0] d);
    rd_bank = b; rd_idx = i; #1; d = rd_data;
  endtask

  task automatic rd24(input logic [1:0] b, output logic [23:0] v);
    logic [7:0] t;
    for (int i = 0; i < 3; i++) begin rd(b, 2'(i), t); v[i*8 +: 8] = t; end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [23:0] v;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd24(2'd1, v); check(v == 0, "R1 pol", v, 0);
    rd24(2'd2, v); check(v == 0, "R1 en", v, 0);
    rd24(2'd3, v); check(v == 0, "R1 id", v, 0);
    check(irq_o == 0 && pending_o == 0, "R1 irq", {pending_o, irq_o}, 0);

    // table walk
    foreach (VEC[k]) begin
      pin_i = VEC[k].pin_a;
      wr24(2'd1, VEC[k].pol);
      wr24(2'd2, VEC[k].en);
      wr24(2'd3, 24'h0);
      @(negedge clk);
      pin_i = VEC[k].pin_b;
      @(negedge clk);
      rd24(2'd3, v);
      check(v == VEC[k].exp, "R2 R3 R4 table id", v, VEC[k].exp);
      check(irq_o == (VEC[k].exp != 0), "R5 table irq", irq_o, VEC[k].exp != 0);
    end

    // R10 readback and unused index
    wr24(2'd1, 24'hC3A517);
    wr24(2'd2, 24'h3C5AE8);
    rd24(2'd1, v); check(v == 24'hC3A517, "R10 pol readback", v, 24'hC3A517);
    rd24(2'd2, v); check(v == 24'h3C5AE8, "R10 en readback", v, 24'h3C5AE8);
    rd(2'd1, 2'd3, b); check(b == 0, "R10 index 3", b, 0);

    // R9 reprogramming with stable pins
    wr24(2'd2, 24'h0); wr24(2'd3, 24'h0);
    pin_i = 24'hFF00FF;
    repeat (2) @(negedge clk);
    wr24(2'd1, 24'h000000);
    wr24(2'd2, 24'hFFFFFF);
    wr24(2'd1, 24'hFFFFFF);
    wr24(2'd1, 24'h00FF00);
    repeat (2) @(negedge clk);
    rd24(2'd3, v); check(v == 0, "R9 no spurious id", v, 0);
    check(irq_o == 0, "R9 irq", irq_o, 0);

    // R8 pending summary for port 2 only
    wr24(2'd1, 24'hFFFFFF);
    pin_i = 24'h000000; @(negedge clk);
    pin_i = 24'h010000; @(negedge clk);
    rd(2'd0, 2'd0, b); check(b == 8'h04, "R8 status read", b, 8'h04);
    check(pending_o == 3'b100, "R8 pending pins", pending_o, 3'b100);
    wr(2'd0, 2'd0, 8'hFF);
    rd(2'd0, 2'd0, b); check(b == 8'h04, "R8 status write ignored", b, 8'h04);
    rd24(2'd3, v); check(v == 24'h010000, "R8 id unchanged", v, 24'h010000);

    // R5 stickiness
    pin_i = 24'h000000;
    repeat (20) @(negedge clk);
    check(irq_o == 1, "R5 sticky irq", irq_o, 1);

    // R6 partial clear
    wr24(2'd3, 24'h0);
    pin_i = 24'hFFFFFF; @(negedge clk);
    wr(2'd3, 2'd0, 8'hF0);
    rd(2'd3, 2'd0, b); check(b == 8'hF0, "R6 clear zeros", b, 8'hF0);
    wr(2'd3, 2'd0, 8'hFF);
    rd(2'd3, 2'd0, b); check(b == 8'hF0, "R6 ones no set", b, 8'hF0);
    rd(2'd3, 2'd1, b); check(b == 8'hFF, "R6 other byte", b, 8'hFF);
    wr24(2'd3, 24'h0);
    check(irq_o == 0, "R5 irq after clear", irq_o, 0);

    // R7 edge coincident with clear
    pin_i = 24'h000000;
    repeat (2) @(negedge clk);
    pin_i = 24'h000001; @(negedge clk);
    wr_en = 1'b1; wr_bank = 2'd3; wr_idx = 2'd0; wr_data = 8'h00;
    pin_i = 24'h000003;
    @(negedge clk);
    wr_en = 1'b0;
    rd(2'd3, 2'd0, b); check(b == 8'h02, "R7 edge wins", b, 8'h02);

    // R1 reset again clears everything
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    rd24(2'd3, v); check(v == 0, "R1 id after reset", v, 0);
    rd24(2'd1, v); check(v == 0, "R1 pol after reset", v, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule